// File: doc/BRIEF.md
# Dual Parallel Port with Byte Handshake

This block is a host-mapped peripheral that provides two 8-bit parallel ports. Each pin can be set to input or output on its own. Each port has a data register and a direction register behind a 4-bit register select. The block does not drive pads itself. Each pin comes out as a separate input value, output value and output enable, and the pad ring combines them.

The block also has two handshake lines for moving bytes between two such blocks, or between this block and a printer-style device:

- **Strobe output.** Any host access to the port B data register drives an active-low strobe output low for one clock.
- **Acknowledge input.** A falling edge on the active-low acknowledge input sets a pending flag in an interrupt register. That flag can pull the active-low interrupt output.

A sender writes a byte to port B and then waits for the acknowledge interrupt before it writes the next byte. If the strobe and acknowledge lines of two blocks are cross-wired, they form a self-timed byte link.

Top module: `dual_pport`

## Requirements
- R1: After a synchronous reset:
  - both data registers and both direction registers are 0, so every output enable is 0 and every output value is 0;
  - the strobe output is 1;
  - the interrupt output is 1;
  - the interrupt mask and pending flag are 0.
- R2: Address 2 holds the port A direction register and address 3 holds the port B direction register. Direction bit 1 enables the output of its pin and bit 0 makes the pin an input. Reading a direction register returns its stored value.
- R3: Address 0 holds the port A data register and address 1 holds the port B data register. A write stores the byte even when the pins are inputs. The stored byte is always presented on the pin output values, and it reaches a pin only through that pin's output enable.
- R4: Reading a data register returns the pin level for each bit: the stored bit where the direction bit is 1, and the external input where the direction bit is 0.
- R5: Every read or write of address 1 drives the strobe output low during the following clock cycle. Accesses to other addresses leave it high, and a single access gives a low pulse of exactly one cycle.
- R6: The acknowledge input passes through a two-stage synchronizer. A 1-to-0 transition on it sets the pending flag three clock edges after the change. A rising edge or a steady level sets nothing.
- R7: Reading the interrupt register at address 13 returns:
  - the pending flag in bit 4;
  - bit 7 = pending AND mask;
  - 0 in every other bit.

  The read clears the pending flag. A new edge arriving in the same cycle as the read wins over the clear.
- R8: A write to address 13 with bit 7 = 1 sets the mask if written bit 4 is 1. A write with bit 7 = 0 clears the mask if written bit 4 is 1. A write with bit 4 = 0 leaves the mask unchanged.
- R9: The interrupt output is low exactly while the pending flag and the mask are both set.
- R10: Addresses 4 to 12, 14 and 15 read as 0x00, including the unused address 11. Writes to them change no state.
- R11: While chip select is 0, nothing is stored, nothing is cleared and no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational while cs=1 and we=0, otherwise 0 |
| pa_in | input | 8 | Port A pin levels from the pads |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels from the pads |
| pb_out | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B output enables |
| strobe_n | output | 1 | Handshake strobe, low one cycle per port B data access |
| ack_n | input | 1 | Handshake acknowledge, falling-edge sensitive |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Read data is combinational, so the bench samples it in the same cycle as the access, between the falling edge and the rising edge. Register writes, mask changes and read-to-clear take effect at the first rising edge of the access. Port outputs and the interrupt output are therefore checked one time step after that edge.

The strobe goes low on the edge that ends the access and is checked there. It is checked high again one edge later.

An acknowledge edge needs three rising edges to show up: two for the synchronizer and one for the pending register. The bench confirms the interrupt is still inactive after two edges and active after the third. The random phase checks every port result against a bench model at these same fixed sample points.

// File: rtl/pport_pkg.sv
package pport_pkg;

    localparam int unsigned DW = 8;
    localparam int unsigned AW = 4;

    localparam logic [AW-1:0] ADR_PORT_A = 4'd0;
    localparam logic [AW-1:0] ADR_PORT_B = 4'd1;
    localparam logic [AW-1:0] ADR_DIR_A  = 4'd2;
    localparam logic [AW-1:0] ADR_DIR_B  = 4'd3;
    localparam logic [AW-1:0] ADR_ICR    = 4'd13;

    // Bit positions inside the interrupt register
    localparam int unsigned ICR_ACK_BIT = 4;
    localparam int unsigned ICR_ANY_BIT = 7;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          wr;
        logic          rd;
    } host_req_t;

    // Pin view: driven bits show the register, other bits show the pad
    function automatic logic [DW-1:0] pin_view(
        input logic [DW-1:0] stored,
        input logic [DW-1:0] dir,
        input logic [DW-1:0] pads
    );
        return (stored & dir) | (pads & ~dir);
    endfunction

endpackage

// File: rtl/pport_lane.sv
module pport_lane
    import pport_pkg::*;
#(
    parameter int unsigned W = DW,
    parameter logic [AW-1:0] SEL_DATA = ADR_PORT_A,
    parameter logic [AW-1:0] SEL_DIR = ADR_DIR_A
) (
    input  logic           clk,
    input  logic           rst,
    input  host_req_t      req,
    input  logic [W-1:0]   wdata,
    input  logic [W-1:0]   pin_in,
    output logic [W-1:0]   pin_out,
    output logic [W-1:0]   pin_oe,
    output logic [W-1:0]   rd_val,
    output logic           rd_hit
);
    logic [W-1:0] data_q;
    logic [W-1:0] dir_q;
    logic         wr_data;
    logic         wr_dir;

    assign wr_data = req.wr && (req.addr == SEL_DATA);
    assign wr_dir  = req.wr && (req.addr == SEL_DIR);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '0;
        end else begin
            if (wr_data) data_q <= wdata;
            if (wr_dir)  dir_q  <= wdata;
        end
    end

    assign pin_out = data_q;
    assign pin_oe  = dir_q;
    assign rd_hit  = req.rd && ((req.addr == SEL_DATA) || (req.addr == SEL_DIR));
    assign rd_val  = (req.addr == SEL_DATA) ? pin_view(data_q, dir_q, pin_in) : dir_q;

    // R3
    data_store_chk: assert property (@(posedge clk) disable iff (rst)
        wr_data |=> pin_out == $past(wdata));

    // R2
    dir_store_chk: assert property (@(posedge clk) disable iff (rst)
        wr_dir |=> pin_oe == $past(wdata));

endmodule

// File: rtl/hs_strobe.sv
module hs_strobe (
    input  logic clk,
    input  logic rst,
    input  logic access,
    output logic strobe_n
);
    always_ff @(posedge clk) begin
        if (rst) strobe_n <= 1'b1;
        else     strobe_n <= ~access;
    end

    // R5
    strobe_after_access_chk: assert property (@(posedge clk) disable iff (rst)
        access |=> !strobe_n);

    // R5
    strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe_n |-> $past(access));

endmodule

// File: rtl/ack_irq_ctl.sv
module ack_irq_ctl (
    input  logic clk,
    input  logic rst,
    input  logic ack_n,
    input  logic icr_rd,
    input  logic icr_wr,
    input  logic wr_setclr,
    input  logic wr_sel,
    output logic pending,
    output logic mask,
    output logic irq_n
);
    logic [2:0] sync_q;
    logic       fall;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 3'b111;
        else     sync_q <= {sync_q[1:0], ack_n};
    end

    assign fall = sync_q[2] && !sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            mask    <= 1'b0;
        end else begin
            pending <= (pending && !icr_rd) || fall;
            if (icr_wr && wr_sel) mask <= wr_setclr;
        end
    end

    assign irq_n = ~(pending & mask);

    // R6
    fall_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
        fall |=> pending);

    // R7
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (icr_rd && !fall) |=> !pending);

    // R8
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        (icr_wr && wr_sel && wr_setclr) |=> mask);

    // R8
    mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !(icr_wr && wr_sel) |=> $stable(mask));

endmodule

// File: rtl/dual_pport.sv
module dual_pport
    import pport_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    input  logic [W-1:0]  pa_in,
    output logic [W-1:0]  pa_out,
    output logic [W-1:0]  pa_oe,
    input  logic [W-1:0]  pb_in,
    output logic [W-1:0]  pb_out,
    output logic [W-1:0]  pb_oe,
    output logic          strobe_n,
    input  logic          ack_n,
    output logic          irq_n
);
    localparam int unsigned NPORT = 2;

    host_req_t req;
    assign req.addr = addr;
    assign req.wr   = cs && we;
    assign req.rd   = cs && !we;

    logic [NPORT-1:0][W-1:0] lane_in;
    logic [NPORT-1:0][W-1:0] lane_out;
    logic [NPORT-1:0][W-1:0] lane_oe;
    logic [NPORT-1:0][W-1:0] lane_rd;
    logic [NPORT-1:0]        lane_hit;

    assign lane_in[0] = pa_in;
    assign lane_in[1] = pb_in;
    assign pa_out = lane_out[0];
    assign pa_oe  = lane_oe[0];
    assign pb_out = lane_out[1];
    assign pb_oe  = lane_oe[1];

    for (genvar g = 0; g < NPORT; g++) begin : g_lane
        pport_lane #(
            .W        (W),
            .SEL_DATA (ADR_PORT_A + AW'(g)),
            .SEL_DIR  (ADR_DIR_A + AW'(g))
        ) u_lane (
            .clk    (clk),
            .rst    (rst),
            .req    (req),
            .wdata  (wdata),
            .pin_in (lane_in[g]),
            .pin_out(lane_out[g]),
            .pin_oe (lane_oe[g]),
            .rd_val (lane_rd[g]),
            .rd_hit (lane_hit[g])
        );
    end

    hs_strobe u_strobe (
        .clk     (clk),
        .rst     (rst),
        .access  (cs && (addr == ADR_PORT_B)),
        .strobe_n(strobe_n)
    );

    logic icr_pending;
    logic icr_mask;
    logic icr_sel;
    assign icr_sel = (addr == ADR_ICR);

    ack_irq_ctl u_irq (
        .clk      (clk),
        .rst      (rst),
        .ack_n    (ack_n),
        .icr_rd   (req.rd && icr_sel),
        .icr_wr   (req.wr && icr_sel),
        .wr_setclr(wdata[ICR_ANY_BIT]),
        .wr_sel   (wdata[ICR_ACK_BIT]),
        .pending  (icr_pending),
        .mask     (icr_mask),
        .irq_n    (irq_n)
    );

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (lane_hit[i]) rdata = lane_rd[i];
        end
        if (req.rd && icr_sel) begin
            rdata[ICR_ACK_BIT] = icr_pending;
            rdata[ICR_ANY_BIT] = icr_pending & icr_mask;
        end
    end

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cs |=> $stable(pa_out) && $stable(pb_out) && $stable(pa_oe) && $stable(pb_oe));

    // R11
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !cs |=> strobe_n);

    // R10
    unused_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cs && !we && addr == 4'd11) |-> rdata == '0);

    // R9
    irq_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (cs && !we && icr_sel) |-> (irq_n == !rdata[ICR_ANY_BIT]));

endmodule

// File: tb/test_dual_pport.sv
module test_dual_pport;
    logic       clk = 1'b0;
    logic       rst, cs, we, ack_n;
    logic [3:0] addr;
    logic [7:0] wdata, rdata, pa_in, pa_out, pa_oe, pb_in, pb_out, pb_oe;
    logic       strobe_n, irq_n;
    int         checks = 0;
    int         fails = 0;
    bit         done = 0;
    logic [7:0] m_da, m_ra, m_db, m_rb;
    logic [7:0] rv;

    always #10 clk = ~clk;

    dual_pport i_dual_pport (
        .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .strobe_n(strobe_n), .ack_n(ack_n), .irq_n(irq_n)
    );

    function automatic logic [7:0] exp_pin(input logic [7:0] d, input logic [7:0] r,
                                           input logic [7:0] p);
        return (d & r) | (p & ~r);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus access; rd holds data sampled mid-cycle. Strobe checked after the edge.
    task automatic bus(input logic w, input logic [3:0] a, input logic [7:0] d,
                       output logic [7:0] rd);
        @(negedge clk);
        cs = 1'b1; we = w; addr = a; wdata = d;
        #2 rd = rdata;
        @(posedge clk);
        #1 cs = 1'b0; we = 1'b0;
        chk("R5 strobe after access", strobe_n, (a == 4'd1) ? 1'b0 : 1'b1);
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check_ports(input string req);
        chk(req, pa_out, m_da);
        chk(req, pa_oe, m_ra);
        chk(req, pb_out, m_db);
        chk(req, pb_oe, m_rb);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; cs = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        pa_in = 8'h00; pb_in = 8'h00; ack_n = 1'b1;
        m_da = 0; m_ra = 0; m_db = 0; m_rb = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        // R1 reset state
        check_ports("R1 reset ports");
        chk("R1 strobe idle", strobe_n, 1'b1);
        chk("R1 irq idle", irq_n, 1'b1);
        bus(1'b0, 4'd13, 8'h00, rv);
        chk("R1 icr zero", rv, 8'h00);

        // R3 store while input
        pa_in = 8'h3C;
        bus(1'b1, 4'd0, 8'hA5, rv); m_da = 8'hA5;
        check_ports("R3 write stored with input dir");
        bus(1'b0, 4'd0, 8'h00, rv);
        chk("R4 read input pins", rv, 8'h3C);
        // R2 direction
        bus(1'b1, 4'd2, 8'hF0, rv); m_ra = 8'hF0;
        check_ports("R2 dir enables outputs");
        bus(1'b0, 4'd2, 8'h00, rv);
        chk("R2 dir readback", rv, 8'hF0);
        bus(1'b0, 4'd0, 8'h00, rv);
        chk("R4 mixed pin read", rv, 8'hAC);

        // R5 one-cycle strobe on port B read and write
        bus(1'b0, 4'd1, 8'h00, rv);
        wait_edges(1);
        chk("R5 strobe one cycle only", strobe_n, 1'b1);
        bus(1'b1, 4'd1, 8'h5A, rv); m_db = 8'h5A;
        wait_edges(1);
        chk("R5 strobe back high", strobe_n, 1'b1);
        check_ports("R3 port B write");

        // R10 unmapped addresses
        bus(1'b1, 4'd11, 8'hFF, rv);
        bus(1'b1, 4'd5, 8'hFF, rv);
        check_ports("R10 unmapped write no effect");
        bus(1'b0, 4'd11, 8'h00, rv);
        chk("R10 reg 11 reads zero", rv, 8'h00);
        bus(1'b0, 4'd15, 8'h00, rv);
        chk("R10 reg 15 reads zero", rv, 8'h00);

        // R11 cs low
        @(negedge clk);
        we = 1'b1; addr = 4'd1; wdata = 8'h11;
        @(posedge clk); #1;
        chk("R11 no strobe without cs", strobe_n, 1'b1);
        we = 1'b0;
        check_ports("R11 no store without cs");

        // R8 enable mask, R6/R9 falling edge timing
        bus(1'b1, 4'd13, 8'h90, rv);
        chk("R8 mask alone no irq", irq_n, 1'b1);
        @(negedge clk) ack_n = 1'b0;
        wait_edges(2);
        chk("R6 not yet pending after two edges", irq_n, 1'b1);
        wait_edges(1);
        chk("R6 R9 irq after third edge", irq_n, 1'b0);
        bus(1'b0, 4'd13, 8'h00, rv);
        chk("R7 icr pending and any", rv, 8'h90);
        chk("R7 R9 read clears irq", irq_n, 1'b1);
        bus(1'b0, 4'd13, 8'h00, rv);
        chk("R7 cleared on read", rv, 8'h00);
        @(negedge clk) ack_n = 1'b1;
        wait_edges(4);
        chk("R6 rising edge ignored", irq_n, 1'b1);
        bus(1'b0, 4'd13, 8'h00, rv);
        chk("R6 rising edge no pending", rv, 8'h00);
        // R8 clear mask, bit4=0 write keeps mask
        bus(1'b1, 4'd13, 8'h10, rv);
        @(negedge clk) ack_n = 1'b0;
        wait_edges(4);
        chk("R9 masked no irq", irq_n, 1'b1);
        bus(1'b0, 4'd13, 8'h00, rv);
        chk("R7 pending without any", rv, 8'h10);
        @(negedge clk) ack_n = 1'b1;
        bus(1'b1, 4'd13, 8'h90, rv);
        bus(1'b1, 4'd13, 8'h00, rv);
        @(negedge clk) ack_n = 1'b0;
        wait_edges(4);
        chk("R8 bit4 zero keeps mask", irq_n, 1'b0);
        bus(1'b0, 4'd13, 8'h00, rv);
        chk("R7 read value masked set", rv, 8'h90);
        @(negedge clk) ack_n = 1'b1;
        wait_edges(3);

        // Random port traffic
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [7:0] d;
            op = int'($urandom % 8);
            d = 8'($urandom);
            pa_in = 8'($urandom);
            pb_in = 8'($urandom);
            case (op)
                0: begin bus(1'b1, 4'd0, d, rv); m_da = d; end
                1: begin bus(1'b1, 4'd1, d, rv); m_db = d; end
                2: begin bus(1'b1, 4'd2, d, rv); m_ra = d; end
                3: begin bus(1'b1, 4'd3, d, rv); m_rb = d; end
                4: begin bus(1'b0, 4'd0, 8'h00, rv);
                         chk("R4 random port A read", rv, exp_pin(m_da, m_ra, pa_in)); end
                5: begin bus(1'b0, 4'd1, 8'h00, rv);
                         chk("R4 random port B read", rv, exp_pin(m_db, m_rb, pb_in)); end
                6: begin bus(1'b0, 4'd3, 8'h00, rv);
                         chk("R2 random dir B read", rv, m_rb); end
                default: begin bus(1'b0, 4'd2, 8'h00, rv);
                         chk("R2 random dir A read", rv, m_ra); end
            endcase
            check_ports("R3 random port outputs");
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule